// File: doc/BRIEF.md
# Two-Stage Watchdog with Free-Running Timebase

This peripheral supervises software through a watchdog that counts a power-of-two number of clock cycles. When the interval runs out for the first time, the block raises an expiry flag. The interrupt output follows that flag as a level. If the interval runs out again before software services it, the block drives a system reset pulse for a fixed number of cycles and latches a sticky reset-seen flag. Software services the watchdog by writing ones to the flag bits. That write clears the flags and also restarts the interval.

Two enable bits in two different word registers must both be set before the watchdog counts. A build option can make the enables sticky once the watchdog has started. The block also contains a free-running timebase counter that software can read to confirm the clock is alive.

Access uses a simple 32-bit register bus. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `wdog_timebase_unit`

## Requirements
- R1: After reset, the words at byte addresses 0x0 and 0x4 read zero, and both `irq` and `sys_rst` are low.
- R2: The word at 0x8 returns the timebase count. It rises by one on every clock and ignores writes.
- R3: The watchdog counts only while word 0x0 bit 1 and word 0x4 bit 0 are both 1. With either bit clear, no expiry ever occurs.
- R4: Exactly 2^INTERVAL_LOG2 clocks after both enables become set, word 0x0 bit 2 (the expiry flag) goes to 1. No reset is produced at that point.
- R5: A second overflow while the expiry flag is set does three things: it sets word 0x0 bit 3 (the reset-seen flag), it drives `sys_rst` high for RST_CYCLES clocks, and it leaves bit 3 set after the pulse ends.
- R6: Writing 1 to word 0x0 bit 2 or bit 3 clears that flag and restarts the interval from zero. Writing 0 to those bits leaves them unchanged, while bit 1 in the same write still updates.
- R7: Clearing either enable stops the watchdog and zeroes its interval count, so a later enable starts a full interval. The flags are kept.
- R8: When LOCK_ONCE is 1 and both enables have been set, writes can no longer clear either enable. Before that point, the enables clear normally.
- R9: `irq` is high exactly while the expiry flag (word 0x0 bit 2) is set.
- R10: An access whose two low address bits are nonzero, or whose address lies beyond 0xB, reads zero and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt, follows the expiry flag |
| sys_rst | output | 1 | System reset pulse |

## Verification
The hardest state to reach from the ports is a re-enable that happens while the expiry flag is still set. After a stop, the very next overflow must produce a reset, and it must come a full interval after the re-enable. The bench first lets the watchdog expire once. It then clears only the enable bit, using a write that carries zeros in the flag positions, and lets the design idle for longer than an interval. Finally it re-enables and counts the exact cycle at which `sys_rst` rises. That cycle proves three things at once: the flag was kept, the write of zero did not clear it, and the count was zeroed by the stop.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic [1:0] {
      REG_CTL_A = 2'd0,
      REG_CTL_B = 2'd1,
      REG_TBASE = 2'd2,
      REG_NONE  = 2'd3
   } reg_sel_e;

   localparam int BIT_RSTSEEN = 3;
   localparam int BIT_EXPIRED = 2;
   localparam int BIT_EN_A    = 1;
   localparam int BIT_EN_B    = 0;
   localparam int WORD_W      = 32;
endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
   parameter int TB_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TB_W-1:0] count
);
   generate
      if (TB_W < 1 || TB_W > 32) begin : g_bad_width
         $error("wdog_timebase: TB_W must be 1..32");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter bit LOCK_ONCE = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  reg_sel_e idx,
   input  logic [3:0] wbits,
   output logic     en_a,
   output logic     en_b,
   output logic     clr_state,
   output logic     clr_rst
);
   logic wr_a, wr_b, lock_now;

   assign wr_a      = wr_en && (idx == REG_CTL_A);
   assign wr_b      = wr_en && (idx == REG_CTL_B);
   assign clr_state = wr_a && wbits[BIT_EXPIRED];
   assign clr_rst   = wr_a && wbits[BIT_RSTSEEN];

   generate
      if (LOCK_ONCE) begin : g_lock
         logic lock_q;
         assign lock_now = lock_q || (en_a && en_b);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lock_q <= 1'b0;
            else        lock_q <= lock_now;
         end
         AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q |=> (en_a && en_b)); // R8
      end else begin : g_nolock
         assign lock_now = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_a <= 1'b0;
         en_b <= 1'b0;
      end else begin
         if (wr_a) en_a <= wbits[BIT_EN_A] || lock_now;
         if (wr_b) en_b <= wbits[BIT_EN_B] || lock_now;
      end
   end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
   parameter int INTERVAL_LOG2 = 16,
   parameter int RST_CYCLES    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr_state,
   input  logic clr_rst,
   output logic expired,
   output logic rst_seen,
   output logic pulse
);
   localparam int CW = INTERVAL_LOG2;
   localparam int PW = $clog2(RST_CYCLES + 1);

   generate
      if (INTERVAL_LOG2 < 2 || INTERVAL_LOG2 > 31) begin : g_bad_interval
         $error("wdog_core: INTERVAL_LOG2 must be 2..31");
      end
      if (RST_CYCLES < 1) begin : g_bad_pulse
         $error("wdog_core: RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [PW-1:0] pcnt;
   logic kick, wrap, fire;

   assign kick  = clr_state || clr_rst;
   assign wrap  = run && (cnt == '1);
   assign fire  = wrap && !kick;
   assign pulse = (pcnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || kick)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expired  <= 1'b0;
         rst_seen <= 1'b0;
         pcnt     <= '0;
      end else begin
         if (clr_state)  expired <= 1'b0;
         else if (fire)  expired <= 1'b1;

         if (clr_rst)               rst_seen <= 1'b0;
         else if (fire && expired)  rst_seen <= 1'b1;

         if (fire && expired)  pcnt <= PW'(RST_CYCLES);
         else if (pulse)       pcnt <= pcnt - 1'b1;
      end
   end

   AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_state |=> !expired); // R6
   AST_FIRST_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> $past(run)); // R4
   AST_RST_NEEDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse) |-> $past(expired)); // R5
   AST_SEEN_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_seen) |-> pulse); // R5
endmodule

// File: rtl/wdog_timebase_unit.sv
module wdog_timebase_unit
   import wdog_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int TB_W          = 32,
   parameter int INTERVAL_LOG2 = 16,
   parameter int RST_CYCLES    = 16,
   parameter bit LOCK_ONCE     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              sys_rst
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("wdog_timebase_unit: ADDR_W must be at least 4");
      end
   endgenerate

   logic            addr_ok;
   reg_sel_e        idx;
   logic [TB_W-1:0] tb;
   logic            en_a, en_b, clr_state, clr_rst;
   logic            expired, rst_seen, pulse;
   logic            unused_wdata;

   assign unused_wdata = ^bus_wdata[31:4];
   assign addr_ok = bus_sel && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
   assign idx     = addr_ok ? reg_sel_e'(bus_addr[3:2]) : REG_NONE;

   wdog_timebase #(.TB_W(TB_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .count(tb)
   );

   wdog_regs #(.LOCK_ONCE(LOCK_ONCE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .idx(idx),
      .wbits(bus_wdata[3:0]), .en_a(en_a), .en_b(en_b),
      .clr_state(clr_state), .clr_rst(clr_rst)
   );

   wdog_core #(.INTERVAL_LOG2(INTERVAL_LOG2), .RST_CYCLES(RST_CYCLES)) u_core (
      .clk(clk), .rst_n(rst_n), .run(en_a && en_b),
      .clr_state(clr_state), .clr_rst(clr_rst),
      .expired(expired), .rst_seen(rst_seen), .pulse(pulse)
   );

   always_comb begin
      bus_rdata = '0;
      if (!bus_wr) begin
         unique case (idx)
            REG_CTL_A: begin
               bus_rdata[BIT_RSTSEEN] = rst_seen;
               bus_rdata[BIT_EXPIRED] = expired;
               bus_rdata[BIT_EN_A]    = en_a;
            end
            REG_CTL_B: bus_rdata[BIT_EN_B] = en_b;
            REG_TBASE: bus_rdata = WORD_W'(tb);
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign irq     = expired;
   assign sys_rst = pulse;
endmodule

// File: tb/tb_wdog_timebase_unit.sv
module tb_wdog_timebase_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NLOG = 6;
   localparam int IVL  = 1 << NLOG;
   localparam int PUL  = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel0 = 1'b0, sel1 = 1'b0, wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata0, rdata1;
   logic irq0, irq1, rst0, rst1;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_timebase_unit #(.ADDR_W(4), .TB_W(32), .INTERVAL_LOG2(NLOG),
      .RST_CYCLES(PUL), .LOCK_ONCE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel0), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata0), .irq(irq0), .sys_rst(rst0));

   wdog_timebase_unit #(.ADDR_W(4), .TB_W(32), .INTERVAL_LOG2(NLOG),
      .RST_CYCLES(PUL), .LOCK_ONCE(1'b1)) dut_once (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel1), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata1), .irq(irq1), .sys_rst(rst1));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_word(bit u, logic [3:0] a, logic [31:0] d);
      if (u) sel1 = 1'b1; else sel0 = 1'b1;
      wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      sel0 = 1'b0; sel1 = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_word(bit u, logic [3:0] a, output logic [31:0] d);
      if (u) sel1 = 1'b1; else sel0 = 1'b1;
      wr = 1'b0; addr = a;
      #1;
      d = u ? rdata1 : rdata0;
      sel0 = 1'b0; sel1 = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd_word(0, 4'h0, v); check("R1 ctl_a", v, 32'h0);
      rd_word(0, 4'h4, v); check("R1 ctl_b", v, 32'h0);
      check("R1 irq", {31'b0, irq0}, 32'h0);
      check("R1 sys_rst", {31'b0, rst0}, 32'h0);
   endtask

   task automatic t_timebase();
      logic [31:0] v1, v2;
      rd_word(0, 4'h8, v1); tick(1); rd_word(0, 4'h8, v2);
      check("R2 step", v2 - v1, 32'd1);
      rd_word(0, 4'h8, v1);
      wr_word(0, 4'h8, 32'h0);
      rd_word(0, 4'h8, v2);
      check("R2 write ignored", v2 - v1, 32'd1);
   endtask

   task automatic t_misaligned();
      logic [31:0] v;
      wr_word(0, 4'h5, 32'h1);
      rd_word(0, 4'h4, v); check("R10 misaligned write", v, 32'h0);
      wr_word(0, 4'h4, 32'h1);
      rd_word(0, 4'h5, v); check("R10 misaligned read", v, 32'h0);
      rd_word(0, 4'hC, v); check("R10 unmapped read", v, 32'h0);
      wr_word(0, 4'h4, 32'h0);
   endtask

   task automatic t_half_enable();
      logic [31:0] v;
      wr_word(0, 4'h0, 32'h2);
      tick(3 * IVL);
      rd_word(0, 4'h0, v); check("R3 only en_a", v, 32'h2);
      wr_word(0, 4'h0, 32'h0);
      wr_word(0, 4'h4, 32'h1);
      tick(3 * IVL);
      rd_word(0, 4'h0, v); check("R3 only en_b", v, 32'h0);
      check("R3 irq quiet", {31'b0, irq0}, 32'h0);
      wr_word(0, 4'h4, 32'h0);
   endtask

   task automatic t_two_stage();
      logic [31:0] v;
      wr_word(0, 4'h0, 32'h2);
      wr_word(0, 4'h4, 32'h1);
      tick(IVL - 1);
      rd_word(0, 4'h0, v); check("R4 before first", v, 32'h2);
      check("R9 irq low", {31'b0, irq0}, 32'h0);
      tick(1);
      rd_word(0, 4'h0, v); check("R4 first expiry", v, 32'h6);
      check("R9 irq high", {31'b0, irq0}, 32'h1);
      check("R4 no reset", {31'b0, rst0}, 32'h0);
      tick(IVL - 1);
      check("R5 before second", {31'b0, rst0}, 32'h0);
      tick(1);
      rd_word(0, 4'h0, v); check("R5 seen set", v, 32'hE);
      check("R5 pulse start", {31'b0, rst0}, 32'h1);
      tick(PUL - 1);
      check("R5 pulse held", {31'b0, rst0}, 32'h1);
      tick(1);
      check("R5 pulse end", {31'b0, rst0}, 32'h0);
      rd_word(0, 4'h0, v); check("R5 seen sticky", v, 32'hE);
      wr_word(0, 4'h0, 32'hE);
      rd_word(0, 4'h0, v); check("R6 flags cleared", v, 32'h2);
      check("R9 irq cleared", {31'b0, irq0}, 32'h0);
      tick(IVL - 1);
      rd_word(0, 4'h0, v); check("R6 restart full interval", v, 32'h2);
      tick(1);
      rd_word(0, 4'h0, v); check("R6 expiry after kick", v, 32'h6);
   endtask

   task automatic t_stop_keep();
      logic [31:0] v;
      wr_word(0, 4'h0, 32'h0);
      rd_word(0, 4'h0, v); check("R6 zero write keeps flag", v, 32'h4);
      tick(3 * IVL);
      check("R7 stopped no reset", {31'b0, rst0}, 32'h0);
      rd_word(0, 4'h0, v); check("R7 flag kept", v, 32'h4);
      wr_word(0, 4'h0, 32'h2);
      tick(IVL - 1);
      check("R7 count zeroed", {31'b0, rst0}, 32'h0);
      tick(1);
      check("R7 reset after full interval", {31'b0, rst0}, 32'h1);
      wr_word(0, 4'h0, 32'hC);
      tick(PUL + 1);
      rd_word(0, 4'h0, v); check("R6 clear and disable", v, 32'h0);
   endtask

   task automatic t_periodic_kick();
      logic [31:0] v;
      wr_word(0, 4'h0, 32'h2);
      for (int i = 0; i < 6; i++) begin
         tick(IVL - 10);
         wr_word(0, 4'h0, 32'h6);
      end
      rd_word(0, 4'h0, v); check("R6 kicked never expires", v, 32'h2);
      wr_word(0, 4'h0, 32'h0);
      wr_word(0, 4'h4, 32'h0);
   endtask

   task automatic t_enable_once();
      logic [31:0] v;
      wr_word(1, 4'h0, 32'h2);
      wr_word(1, 4'h0, 32'h0);
      rd_word(1, 4'h0, v); check("R8 clear before run", v, 32'h0);
      wr_word(1, 4'h0, 32'h2);
      wr_word(1, 4'h4, 32'h1);
      wr_word(1, 4'h0, 32'h0);
      wr_word(1, 4'h4, 32'h0);
      rd_word(1, 4'h0, v); check("R8 en_a locked", v, 32'h2);
      rd_word(1, 4'h4, v); check("R8 en_b locked", v, 32'h1);
      tick(IVL);
      check("R8 still running", {31'b0, irq1}, 32'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_timebase();
      t_misaligned();
      t_half_enable();
      t_two_stage();
      t_stop_keep();
      t_periodic_kick();
      t_enable_once();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule